// File: doc/BRIEF.md
# Configurable Logic-Device Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It receives the sum term that an AND/OR array has already formed, plus a handful of dedicated product-term lines. A static configuration word decides how the cell behaves. The cell can pass the sum straight to its outputs, or hold it in a storage bit that works as a D or a T flip-flop. Each control of that storage bit can come from a shared global line or from a local product term: the clock, the clock enable, the set, the reset and the pad output enable. The chosen clock can also be inverted in each cell.

The cell runs inside a faster system clock domain. The global clock lines and the product-term clock are treated as sampled levels. An "active edge" is a rising transition of the chosen and optionally inverted level, seen between two consecutive system clock samples. Set and reset do not wait for that edge or for the clock enable. They take hold at the next system clock. The result goes both to the pad and back to the routing matrix. The configuration word is changed only while `rst` is high.

Top module: `mc_cell`

## Requirements
- R1: While `rst` is high, the storage bit clears to 0 at each system clock edge. With the register in use, both outputs then read 0.
- R2: With `cfg[0]` (bypass) set to 1, `pad_out` and `fb_out` follow `pt_sum` combinationally, in the same cycle.
- R3: With `cfg[0]`=0 and `cfg[1]`=0 (D type), an active edge with the enable true loads `pt_sum`. The new value is visible after the system clock edge at which that edge is sampled.
- R4: With `cfg[1]`=1 (T type), an enabled active edge inverts the stored bit when `pt_sum` is 1 and leaves it unchanged when `pt_sum` is 0.
- R5: `cfg[3:2]` selects the clock source: 0, 1 and 2 select `gclk[0]`, `gclk[1]` and `gclk[2]`, and 3 selects `pt_clk`. Transitions on lines that are not selected have no effect.
- R6: With `cfg[4]`=1 the selected clock is inverted, so the register acts on a falling transition of the line.
- R7: With `cfg[5]`=1, an active edge is ignored while `pt_ce` is 0. With `cfg[5]`=0, every active edge is enabled.
- R8: `cfg[7:6]` selects the set source: 1 selects `gsr`, 2 selects `pt_set`, and 0 or 3 disables set. An active set forces the bit to 1 at the next system clock, whatever the clock edge or enable.
- R9: `cfg[9:8]` selects the reset source with the same encoding, using `gsr` and `pt_rst`. An active reset forces the bit to 0 at the next system clock.
- R10: When set and reset are both active, reset wins and the bit becomes 0.
- R11: `cfg[11:10]` selects `pad_oe`: 0 selects `gts[0]`, 1 selects `gts[1]`, 2 selects `pt_oe`, and 3 holds it at 1.
- R12: `fb_out` always equals `pad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every line |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 12 | Static configuration word |
| gclk | input | 3 | Global clock lines (sampled levels) |
| gsr | input | 1 | Global set/reset line |
| gts | input | 2 | Global output-enable lines |
| pt_sum | input | 1 | Sum term from the logic array |
| pt_clk | input | 1 | Product-term clock |
| pt_ce | input | 1 | Product-term clock enable |
| pt_set | input | 1 | Product-term set |
| pt_rst | input | 1 | Product-term reset |
| pt_oe | input | 1 | Product-term output enable |
| fb_out | output | 1 | Cell result fed back to the routing matrix |
| pad_out | output | 1 | Cell result driven to the pad |
| pad_oe | output | 1 | Pad driver enable |

## Verification
The assertions assume the configuration word is static between resets. Their hold properties compare the output across two cycles, so a change to the bypass bit outside reset would break them. The stimulus therefore changes `cfg` only while `rst` is high, and it covers all 4096 configuration words in turn. Within each word, the clock lines, set, reset and enable lines are driven randomly. The inputs change only on the falling system clock edge, so every line is a clean level at each sampling edge. Set and reset are each held low most of the time, so that clocked loads and toggles actually occur between forcing events.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int GCK_N = 3;
    localparam int GTS_N = 2;
    localparam int CFG_W = 12;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_GLB  = 2'd1,
        SRC_PT   = 2'd2,
        SRC_OFF  = 2'd3
    } mc_src_e;

    typedef enum logic [1:0] {
        CK_G0 = 2'd0,
        CK_G1 = 2'd1,
        CK_G2 = 2'd2,
        CK_PT = 2'd3
    } mc_ck_e;

    typedef enum logic [1:0] {
        OE_G0 = 2'd0,
        OE_G1 = 2'd1,
        OE_PT = 2'd2,
        OE_ON = 2'd3
    } mc_oe_e;

    typedef struct packed {
        mc_oe_e  oe_sel;
        mc_src_e rst_sel;
        mc_src_e set_sel;
        logic    ce_en;
        logic    clk_inv;
        mc_ck_e  clk_sel;
        logic    ttype;
        logic    bypass;
    } mc_cfg_t;

    typedef struct packed {
        logic clk_lvl;
        logic ce;
        logic set_a;
        logic rst_a;
        logic oe;
    } mc_ctl_t;

    function automatic logic pick_src(mc_src_e s, logic glb, logic pt);
        case (s)
            SRC_GLB: return glb;
            SRC_PT:  return pt;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mc_sel.sv
module mc_sel
    import mc_pkg::*;
(
    input  mc_cfg_t          cfg,
    input  logic [GCK_N-1:0] gclk,
    input  logic             gsr,
    input  logic [GTS_N-1:0] gts,
    input  logic             pt_clk,
    input  logic             pt_ce,
    input  logic             pt_set,
    input  logic             pt_rst,
    input  logic             pt_oe,
    output mc_ctl_t          ctl
);
    logic raw_clk;

    always_comb begin
        case (cfg.clk_sel)
            CK_G0:   raw_clk = gclk[0];
            CK_G1:   raw_clk = gclk[1];
            CK_G2:   raw_clk = gclk[2];
            default: raw_clk = pt_clk;
        endcase
    end

    always_comb begin
        ctl.clk_lvl = raw_clk ^ cfg.clk_inv;
        ctl.ce      = cfg.ce_en ? pt_ce : 1'b1;
        ctl.set_a   = pick_src(cfg.set_sel, gsr, pt_set);
        ctl.rst_a   = pick_src(cfg.rst_sel, gsr, pt_rst);
        case (cfg.oe_sel)
            OE_G0:   ctl.oe = gts[0];
            OE_G1:   ctl.oe = gts[1];
            OE_PT:   ctl.oe = pt_oe;
            default: ctl.oe = 1'b1;
        endcase
    end
endmodule

// File: rtl/mc_edge.sv
module mc_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fire
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= lvl;
    end

    assign fire = lvl & ~lvl_q;
endmodule

// File: rtl/mc_store.sv
module mc_store (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    input  logic fire,
    input  logic ce,
    input  logic set_a,
    input  logic rst_a,
    input  logic ttype,
    output logic q
);
    logic nxt;

    always_comb begin
        nxt = q;
        if (rst_a)            nxt = 1'b0;
        else if (set_a)       nxt = 1'b1;
        else if (fire && ce)  nxt = ttype ? (q ^ d_in) : d_in;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt;
    end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg,
    input  logic [GCK_N-1:0]    gclk,
    input  logic                gsr,
    input  logic [GTS_N-1:0]    gts,
    input  logic                pt_sum,
    input  logic                pt_clk,
    input  logic                pt_ce,
    input  logic                pt_set,
    input  logic                pt_rst,
    input  logic                pt_oe,
    output logic                fb_out,
    output logic                pad_out,
    output logic                pad_oe
);
    mc_cfg_t cw;
    mc_ctl_t ctl;
    logic    fire;
    logic    q;
    logic    cell_val;

    assign cw = mc_cfg_t'(cfg);

    mc_sel u_sel (
        .cfg    (cw),
        .gclk   (gclk),
        .gsr    (gsr),
        .gts    (gts),
        .pt_clk (pt_clk),
        .pt_ce  (pt_ce),
        .pt_set (pt_set),
        .pt_rst (pt_rst),
        .pt_oe  (pt_oe),
        .ctl    (ctl)
    );

    mc_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ctl.clk_lvl),
        .fire (fire)
    );

    mc_store u_store (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pt_sum),
        .fire  (fire),
        .ce    (ctl.ce),
        .set_a (ctl.set_a),
        .rst_a (ctl.rst_a),
        .ttype (cw.ttype),
        .q     (q)
    );

    assign cell_val = cw.bypass ? pt_sum : q;
    assign fb_out   = cell_val;
    assign pad_out  = cell_val;
    assign pad_oe   = ctl.oe;
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk
    import mc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CFG_W-1:0] cfg,
    input logic             gsr,
    input logic             pt_sum,
    input logic             pt_ce,
    input logic             pt_set,
    input logic             pt_rst,
    input logic             fb_out
);
    mc_cfg_t c;
    logic    s_on, r_on, regd;

    assign c    = mc_cfg_t'(cfg);
    assign s_on = pick_src(c.set_sel, gsr, pt_set);
    assign r_on = pick_src(c.rst_sel, gsr, pt_rst);
    assign regd = ~c.bypass;

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        (regd && r_on) |=> (fb_out == 1'b0));

    a_r8_set_forces: assert property (@(posedge clk) disable iff (rst)
        (regd && s_on && !r_on) |=> (fb_out == 1'b1));

    a_r10_reset_wins: assert property (@(posedge clk) disable iff (rst)
        (regd && s_on && r_on) |=> (fb_out == 1'b0));

    a_r7_ce_blocks: assert property (@(posedge clk) disable iff (rst)
        (regd && c.ce_en && !pt_ce && !s_on && !r_on) |=> $stable(fb_out));

    a_r4_t_hold: assert property (@(posedge clk) disable iff (rst)
        (regd && c.ttype && !pt_sum && !s_on && !r_on) |=> $stable(fb_out));
endmodule

bind mc_cell mc_cell_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg    (cfg),
    .gsr    (gsr),
    .pt_sum (pt_sum),
    .pt_ce  (pt_ce),
    .pt_set (pt_set),
    .pt_rst (pt_rst),
    .fb_out (fb_out)
);

// File: tb/sim_mc_cell.sv
module sim_mc_cell;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cfg = '0;
    logic [2:0]  gclk = '0;
    logic        gsr = 0;
    logic [1:0]  gts = '0;
    logic        pt_sum = 0, pt_clk = 0, pt_ce = 0, pt_set = 0, pt_rst = 0, pt_oe = 0;
    logic        fb_out, pad_out, pad_oe;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    ref_q = 0;
    bit    ref_prev = 1;
    string ref_tag = "R1";

    always #5 clk = ~clk;

    mc_cell u0 (
        .clk(clk), .rst(rst), .cfg(cfg), .gclk(gclk), .gsr(gsr), .gts(gts),
        .pt_sum(pt_sum), .pt_clk(pt_clk), .pt_ce(pt_ce), .pt_set(pt_set),
        .pt_rst(pt_rst), .pt_oe(pt_oe),
        .fb_out(fb_out), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic bit src_of(int sel, bit g, bit p);
        if (sel == 1) return g;
        if (sel == 2) return p;
        return 0;
    endfunction

    // behavioural reference, one step per system clock
    always @(posedge clk) begin
        int  ck;
        bit  line, lvl, edge_seen, en, s, r;
        cyc++;
        ck   = int'(cfg[3:2]);
        line = (ck == 3) ? pt_clk : gclk[ck];
        lvl  = line ^ cfg[4];
        if (rst) begin
            ref_q = 0; ref_prev = 1; ref_tag = "R1";
        end else begin
            s = src_of(int'(cfg[7:6]), gsr, pt_set);
            r = src_of(int'(cfg[9:8]), gsr, pt_rst);
            edge_seen = lvl && !ref_prev;
            en = cfg[5] ? pt_ce : 1'b1;
            if (r) begin
                ref_q = 0; ref_tag = s ? "R10" : "R9";
            end else if (s) begin
                ref_q = 1; ref_tag = "R8";
            end else if (edge_seen && en) begin
                if (cfg[1]) begin ref_q = ref_q ^ pt_sum; ref_tag = "R4"; end
                else        begin ref_q = pt_sum;         ref_tag = "R3"; end
                if (cfg[4]) ref_tag = {ref_tag, " R6"};
            end else if (edge_seen) begin
                ref_tag = "R7";
            end else begin
                ref_tag = "R5";
            end
            ref_prev = lvl;
        end
    end

    task automatic check(string tag, bit got, bit exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s cfg=%03h got=%0b exp=%0b t=%0t", tag, cfg, got, exp, $time);
        end
    endtask

    task automatic compare_now();
        bit eo, eoe;
        eo = cfg[0] ? pt_sum : ref_q;
        case (cfg[11:10])
            2'd0: eoe = gts[0];
            2'd1: eoe = gts[1];
            2'd2: eoe = pt_oe;
            default: eoe = 1;
        endcase
        check(cfg[0] ? "R2" : ref_tag, pad_out, eo);
        check("R12", fb_out, pad_out);
        check("R11", pad_oe, eoe);
    endtask

    task automatic drive_random();
        gclk   = 3'($urandom);
        pt_clk = 1'($urandom);
        pt_sum = 1'($urandom);
        pt_ce  = 1'($urandom);
        pt_oe  = 1'($urandom);
        gts    = 2'($urandom);
        gsr    = ($urandom % 8) == 0;
        pt_set = ($urandom % 8) == 0;
        pt_rst = ($urandom % 8) == 0;
    endtask

    task automatic quiet();
        gclk = '0; pt_clk = 0; gsr = 0; pt_set = 0; pt_rst = 0;
    endtask

    // watchdog
    initial begin
        wait (cyc > 190000);
        n_bad++;
        $display("FAIL watchdog expired after %0d cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // directed: R1 reset state, then R3 load via gclk[1], R5 other line ignored
        rst = 1; cfg = 12'h004;   // D type, clock gclk[1]
        quiet();
        repeat (2) @(negedge clk);
        check("R1", pad_out, 1'b0);
        rst = 0; pt_sum = 1;
        @(negedge clk);
        gclk[0] = 1;                       // R5: unselected line
        @(negedge clk);
        check("R5", pad_out, 1'b0);
        gclk[1] = 1;                       // rising edge on selected line
        @(negedge clk);
        check("R3", pad_out, 1'b1);
        // directed R6: inverted pt clock, T type
        rst = 1; cfg = 12'h01E; quiet(); pt_clk = 1;
        repeat (2) @(negedge clk);
        rst = 0; pt_sum = 1;
        @(negedge clk);
        pt_clk = 0;                        // falling line = active edge
        @(negedge clk);
        check("R6", pad_out, 1'b1);
        check("R4", fb_out, 1'b1);

        // full sweep of every configuration word
        for (int w = 0; w < 4096; w++) begin
            @(negedge clk);
            rst = 1; cfg = 12'(w); quiet();
            @(negedge clk);
            compare_now();
            @(negedge clk);
            compare_now();
            rst = 0;
            drive_random();
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                compare_now();
                drive_random();
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule